// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers five status conditions from a token-passing network controller into a flag register, gates each flag with a bit of a write-only mask register, and produces one active-high interrupt request. The receive, transmit, reconfiguration, NAK and next-ID logic send one-cycle set pulses. Software command strobes and a read of the next-ID register clear the flags. Each flag has its own clear path.

Masking only decides whether a flag reaches the interrupt line. A masked flag stays set. It raises the interrupt again as soon as its mask bit is set, unless it was cleared first. The flag register is available for status reads. The interrupt output is registered, so it follows the flag and mask registers by one clock.

Top module: `irq_status_ctrl`

## Requirements
- R1: After synchronous reset the mask register holds all zeros, every status bit reads 0 and `irq` is 0. With the mask left at its reset value, setting flags does not raise `irq`.
- R2: `irq` is registered. It equals the OR over all bit positions of (status AND mask), as those registers stood one clock earlier. A flag set by an event is visible on `status` one clock after the pulse, and on `irq` one clock after that.
- R3: Each mask bit gates the status bit at the same position, and a 1 enables it. The positions are: receiver inhibited at bit 7, excessive NAK at bit 4, reconfiguration timer at bit 3, new next ID at bit 2, transmitter available at bit 0.
- R4: Clearing a mask bit hides its flag from `irq` but leaves the flag set. Setting the mask bit again brings the interrupt back.
- R5: The reconfiguration flag is cleared by `cmd_clr_flags`. No other strobe clears it.
- R6: The excessive-NAK flag is cleared only by `cmd_por_clr`.
- R7: The new-next-ID flag is cleared by `nid_rd`, the strobe for a read of the next-ID register, and by no other strobe.
- R8: The receiver-inhibited flag is cleared by `cmd_rx_en`. The transmitter-available flag is cleared by `cmd_tx_start`. Each strobe leaves the other flag alone.
- R9: When a set pulse and a clear strobe for the same flag arrive in the same cycle, the flag ends up set.
- R10: Bits 6, 5 and 1 are not implemented. Writes to them are dropped, they read as 0 in `status`, and they never raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 8 | Mask value to write |
| ev_ri | input | 1 | Set pulse: receiver inhibited |
| ev_ta | input | 1 | Set pulse: transmitter available |
| ev_recon | input | 1 | Set pulse: reconfiguration timer expired |
| ev_excnak | input | 1 | Set pulse: excessive NAK |
| ev_newnid | input | 1 | Set pulse: new next ID |
| cmd_rx_en | input | 1 | Receive-enable command; clears receiver inhibited |
| cmd_tx_start | input | 1 | Transmit-start command; clears transmitter available |
| cmd_clr_flags | input | 1 | Clear-flags command; clears reconfiguration |
| cmd_por_clr | input | 1 | Power-on clear command; clears excessive NAK |
| nid_rd | input | 1 | Read of the next-ID register; clears new next ID |
| status | output | 8 | Flag register for reads |
| irq | output | 1 | Registered interrupt request |

## Verification
The main sweep tries all 256 mask values against all 32 combinations of the five flags. Each combination is checked against an arithmetic OR-of-AND. This separates wrong bit positions, missing gating and leakage from unimplemented bits. Directed sequences then try each clear strobe against every flag, to show which flags it clears and which it must leave alone. The mask is toggled off and on over a flag that stays set, which separates hiding a flag from clearing it. Set and clear pulses are applied together, both on a clear flag and on one already set, to show that the set wins. The cycle right after a set pulse is checked separately to confirm the single register delay on `irq`.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int STAT_W     = 8;
  localparam int BIT_RI     = 7;
  localparam int BIT_EXCNAK = 4;
  localparam int BIT_RECON  = 3;
  localparam int BIT_NEWNID = 2;
  localparam int BIT_TA     = 0;
  localparam logic [STAT_W-1:0] IMPL_BITS =
    STAT_W'((1 << BIT_RI) | (1 << BIT_EXCNAK) | (1 << BIT_RECON) |
            (1 << BIT_NEWNID) | (1 << BIT_TA));
endpackage

// File: rtl/isc_flag_bank.sv
module isc_flag_bank #(
  parameter int W = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= set_i[i] | (q & ~clr_i[i]);
      end
      assign flags_o[i] = q;
    end else begin : g_none
      assign flags_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/isc_mask_reg.sv
module isc_mask_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;
  always_ff @(posedge clk) begin
    if (rst)       mask_q <= '0;
    else if (we_i) mask_q <= wdata_i & IMPL;
  end
  assign mask_o = mask_q;
endmodule

// File: rtl/isc_irq_gen.sv
module isc_irq_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] flags_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic irq_q;
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags_i & mask_i);
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import isc_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  input  logic         ev_ri,
  input  logic         ev_ta,
  input  logic         ev_recon,
  input  logic         ev_excnak,
  input  logic         ev_newnid,
  input  logic         cmd_rx_en,
  input  logic         cmd_tx_start,
  input  logic         cmd_clr_flags,
  input  logic         cmd_por_clr,
  input  logic         nid_rd,
  output logic [W-1:0] status,
  output logic         irq
);
  localparam logic [W-1:0] IMPL = W'(IMPL_BITS);

  logic [W-1:0] set_vec;
  logic [W-1:0] clr_vec;
  logic [W-1:0] flags;
  logic [W-1:0] mask_q;

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    set_vec[BIT_RI]     = ev_ri;
    set_vec[BIT_TA]     = ev_ta;
    set_vec[BIT_RECON]  = ev_recon;
    set_vec[BIT_EXCNAK] = ev_excnak;
    set_vec[BIT_NEWNID] = ev_newnid;
    clr_vec[BIT_RI]     = cmd_rx_en;
    clr_vec[BIT_TA]     = cmd_tx_start;
    clr_vec[BIT_RECON]  = cmd_clr_flags;
    clr_vec[BIT_EXCNAK] = cmd_por_clr;
    clr_vec[BIT_NEWNID] = nid_rd;
  end

  isc_flag_bank #(.W(W), .IMPL(IMPL)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_vec), .clr_i(clr_vec), .flags_o(flags)
  );

  isc_mask_reg #(.W(W), .IMPL(IMPL)) u_mask (
    .clk(clk), .rst(rst), .we_i(mask_we), .wdata_i(mask_wdata), .mask_o(mask_q)
  );

  isc_irq_gen #(.W(W)) u_irq (
    .clk(clk), .rst(rst), .flags_i(flags), .mask_i(mask_q), .irq_o(irq)
  );

  assign status = flags;
endmodule

// File: rtl/isc_chk.sv
module isc_chk
  import isc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              mask_we,
  input logic [STAT_W-1:0] mask_wdata,
  input logic              ev_recon,
  input logic              ev_excnak,
  input logic              ev_newnid,
  input logic              cmd_clr_flags,
  input logic              cmd_por_clr,
  input logic              nid_rd,
  input logic [STAT_W-1:0] status,
  input logic [STAT_W-1:0] mask_q,
  input logic              irq
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && mask_q == '0)); // R1
  AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (irq == |($past(status) & $past(mask_q)))); // R2
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> (mask_q == ($past(mask_wdata) & IMPL_BITS))); // R3
  AST_RECON_HOLD: assert property (@(posedge clk) disable iff (rst)
    (status[BIT_RECON] && !cmd_clr_flags) |=> status[BIT_RECON]); // R5
  AST_EXCNAK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (status[BIT_EXCNAK] && !cmd_por_clr) |=> status[BIT_EXCNAK]); // R6
  AST_NID_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (nid_rd && !ev_newnid) |=> !status[BIT_NEWNID]); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (ev_recon || ev_excnak) |=> (status[BIT_RECON] || !$past(ev_recon)) &&
                                (status[BIT_EXCNAK] || !$past(ev_excnak))); // R9
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((status & ~IMPL_BITS) == '0) && ((mask_q & ~IMPL_BITS) == '0)); // R10
endmodule

bind irq_status_ctrl isc_chk u_chk (
  .clk(clk), .rst(rst), .mask_we(mask_we), .mask_wdata(mask_wdata),
  .ev_recon(ev_recon), .ev_excnak(ev_excnak), .ev_newnid(ev_newnid),
  .cmd_clr_flags(cmd_clr_flags), .cmd_por_clr(cmd_por_clr), .nid_rd(nid_rd),
  .status(status), .mask_q(mask_q), .irq(irq)
);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mask_we = 0;
  logic [7:0] mask_wdata = '0;
  logic ev_ri = 0, ev_ta = 0, ev_recon = 0, ev_excnak = 0, ev_newnid = 0;
  logic cmd_rx_en = 0, cmd_tx_start = 0, cmd_clr_flags = 0, cmd_por_clr = 0, nid_rd = 0;
  logic [7:0] status;
  logic irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_status_ctrl dut (
    .clk(clk), .rst(rst), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .ev_ri(ev_ri), .ev_ta(ev_ta), .ev_recon(ev_recon), .ev_excnak(ev_excnak),
    .ev_newnid(ev_newnid), .cmd_rx_en(cmd_rx_en), .cmd_tx_start(cmd_tx_start),
    .cmd_clr_flags(cmd_clr_flags), .cmd_por_clr(cmd_por_clr), .nid_rd(nid_rd),
    .status(status), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    mask_we = 0; ev_ri = 0; ev_ta = 0; ev_recon = 0; ev_excnak = 0; ev_newnid = 0;
    cmd_rx_en = 0; cmd_tx_start = 0; cmd_clr_flags = 0; cmd_por_clr = 0; nid_rd = 0;
  endtask

  task automatic fire(input logic [7:0] v);
    ev_ri = v[7]; ev_excnak = v[4]; ev_recon = v[3]; ev_newnid = v[2]; ev_ta = v[0];
  endtask

  task automatic wmask(input logic [7:0] m);
    mask_we = 1; mask_wdata = m;
  endtask

  task automatic clear_all();
    cmd_rx_en = 1; cmd_tx_start = 1; cmd_clr_flags = 1; cmd_por_clr = 1; nid_rd = 1;
    tick(); idle();
  endtask

  function automatic logic [7:0] pat2vec(input int p);
    return {p[4], 2'b00, p[3], p[2], p[1], 1'b0, p[0]};
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) tick();
    rst = 0;
    // R1: reset state, then flags with reset mask keep irq low
    chk("R1 status", status, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    fire(8'h9D); tick(); idle(); tick();
    chk("R1 status set", status, 8'h9D);
    chk("R1 irq with reset mask", {7'd0, irq}, 8'h00);
    clear_all(); tick();

    // R2: one-cycle irq latency after status
    wmask(8'h08); fire(8'h08); tick(); idle();
    chk("R2 status next cycle", status, 8'h08);
    chk("R2 irq not yet", {7'd0, irq}, 8'h00);
    tick();
    chk("R2 irq one later", {7'd0, irq}, 8'h01);
    clear_all(); tick();
    chk("R2 irq drops", {7'd0, irq}, 8'h00);

    // R2 R3 R10: full sweep of masks against flag combinations
    for (int m = 0; m < 256; m++) begin
      for (int p = 0; p < 32; p++) begin
        logic [7:0] v;
        v = pat2vec(p);
        wmask(8'(m)); fire(v); tick(); idle();
        chk("R3 status", status, v);
        tick();
        chk("R2 R3 R10 irq", {7'd0, irq}, {7'd0, |(v & 8'(m))});
        clear_all();
      end
    end

    // R10: undefined bits never raise irq
    wmask(8'h62); fire(8'h9D); tick(); idle(); tick();
    chk("R10 status undef", status & 8'h62, 8'h00);
    chk("R10 irq undef mask", {7'd0, irq}, 8'h00);
    clear_all();

    // R4: hiding RI and TA without clearing
    wmask(8'h81); fire(8'h81); tick(); idle(); tick();
    chk("R4 irq on", {7'd0, irq}, 8'h01);
    wmask(8'h00); tick(); idle(); tick();
    chk("R4 irq hidden", {7'd0, irq}, 8'h00);
    chk("R4 flags kept", status, 8'h81);
    wmask(8'h80); tick(); idle(); tick();
    chk("R4 RI irq returns", {7'd0, irq}, 8'h01);
    wmask(8'h01); tick(); idle(); tick();
    chk("R4 TA irq returns", {7'd0, irq}, 8'h01);
    clear_all();

    // R5 R6 R7 R8: each strobe clears only its own flag
    fire(8'h9D); tick(); idle();
    cmd_clr_flags = 1; tick(); idle();
    chk("R5 clear-flags", status, 8'h95);
    cmd_rx_en = 1; tick(); idle();
    chk("R8 rx enable", status, 8'h15);
    cmd_tx_start = 1; tick(); idle();
    chk("R8 tx start", status, 8'h14);
    nid_rd = 1; tick(); idle();
    chk("R7 next-id read", status, 8'h10);
    cmd_por_clr = 1; tick(); idle();
    chk("R6 por clear", status, 8'h00);

    fire(8'h08); tick(); idle();
    cmd_por_clr = 1; cmd_rx_en = 1; cmd_tx_start = 1; nid_rd = 1; tick(); idle();
    chk("R5 recon kept by others", status, 8'h08);
    clear_all();

    fire(8'h10); tick(); idle();
    cmd_clr_flags = 1; cmd_rx_en = 1; cmd_tx_start = 1; nid_rd = 1; tick(); idle();
    chk("R6 excnak kept by others", status, 8'h10);
    clear_all();

    fire(8'h04); tick(); idle();
    cmd_clr_flags = 1; cmd_por_clr = 1; cmd_rx_en = 1; cmd_tx_start = 1; tick(); idle();
    chk("R7 nid kept by others", status, 8'h04);
    clear_all();

    // R9: set beats clear, from clear and from set state
    fire(8'h9D); cmd_rx_en = 1; cmd_tx_start = 1; cmd_clr_flags = 1;
    cmd_por_clr = 1; nid_rd = 1; tick(); idle();
    chk("R9 set wins from clear", status, 8'h9D);
    fire(8'h9D); cmd_rx_en = 1; cmd_tx_start = 1; cmd_clr_flags = 1;
    cmd_por_clr = 1; nid_rd = 1; tick(); idle();
    chk("R9 set wins from set", status, 8'h9D);
    clear_all();
    chk("R9 then cleared", status, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule